// File: doc/BRIEF.md
# PC-Indexed Stride Prefetcher

This block watches the stream of cache misses leaving a core. Each miss carries the address of the memory instruction that caused it and the data address it touched. A direct-mapped table, indexed and tagged by the instruction address, remembers for each instruction the data address of its previous miss, the difference between its last two addresses, and a confidence count. The count grows each time the same difference shows up again.

When an instruction's confidence passes a programmable threshold, the block emits one prefetch request for the current address plus the learned stride. The request goes out on a valid/ready port. Because every instruction has its own entry, several arrays that are walked in an interleaved loop each keep their own stride. They do not blur into one irregular address stream.

Two configuration inputs shape how aggressive the block is: a saturation ceiling for the count and a bound on the stride magnitude it may run ahead by.

Top module: `stride_pf`

## Requirements
- R1: After reset, pf_valid_o is low and every table entry is invalid, so the first miss from any instruction produces no request.
- R2: The table is direct-mapped. The index is miss_pc_i[IDX_W-1:0] and the tag is the remaining upper PC bits. A miss whose tag differs from the one stored at its index replaces that entry.
- R3: A miss that finds no matching entry allocates it with the miss address as last address, a stride of zero and a count of zero. It issues no request.
- R4: On a tag match, the observed stride is miss_addr_i minus the stored last address, modulo 2^ADDR_W. If it equals the stored stride, the count increments. A request for miss_addr_i plus the stride is raised on pf_valid_o/pf_addr_o in the cycle after the miss, provided the updated count is strictly greater than cfg_thresh_i.
- R5: On a tag match with a differing observed stride, the stored stride is replaced, the count returns to zero, and no request is issued.
- R6: A stored stride of zero never produces a request, however high its count.
- R7: The count saturates at cfg_cnt_max_i. If that ceiling is not above cfg_thresh_i, nothing is issued.
- R8: No request is issued when the magnitude of the stride, read as a two's complement value, exceeds cfg_max_dist_i. Training continues regardless.
- R9: While pf_valid_o is high and pf_ready_i is low, pf_addr_o is held. Any request that would be generated meanwhile is dropped, while the table still trains.
- R10: Negative strides are learned and applied with two's complement wrap.
- R11: Misses from different instructions at different indices train independently when interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | A miss is presented this cycle |
| miss_pc_i | input | PC_W | Instruction address of the miss |
| miss_addr_i | input | ADDR_W | Data address of the miss |
| cfg_thresh_i | input | CNT_W | Count must exceed this to issue |
| cfg_cnt_max_i | input | CNT_W | Saturation ceiling of the count |
| cfg_max_dist_i | input | ADDR_W | Largest stride magnitude allowed to issue |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_ready_i | input | 1 | Consumer accepts the request |
| pf_addr_o | output | ADDR_W | Prefetch address |

## Verification
The bench builds the block with 16-bit PCs and addresses, IDX_W = 2 and CNT_W = 3. The four-entry table makes aliasing between instructions trivial to provoke, and 16-bit addresses let a negative stride wrap visibly. A 3-bit count lets the saturation ceiling be set both below and above the threshold within a few misses. The distance bound is first set below a large stride and then raised, so the same trained stream shows both the suppressed and the issuing outcome.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

  typedef enum logic [1:0] {
    ACT_ALLOC   = 2'd0,
    ACT_RETRAIN = 2'd1,
    ACT_CONFIRM = 2'd2
  } train_act_e;

endpackage

// File: rtl/stride_pf_table.sv
module stride_pf_table #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   pc_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] last_o,
  output logic [ADDR_W-1:0] stride_o,
  output logic [CNT_W-1:0]  cnt_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_last_i,
  input  logic [ADDR_W-1:0] wr_stride_i,
  input  logic [CNT_W-1:0]  wr_cnt_i
);

  localparam int unsigned TAG_W   = PC_W - IDX_W;
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;

  logic              vld_q    [ENTRIES];
  logic [TAG_W-1:0]  tag_q    [ENTRIES];
  logic [ADDR_W-1:0] last_q   [ENTRIES];
  logic [ADDR_W-1:0] stride_q [ENTRIES];
  logic [CNT_W-1:0]  cnt_q    [ENTRIES];

  assign idx = pc_i[IDX_W-1:0];
  assign tag = pc_i[PC_W-1:IDX_W];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (idx == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e]    <= 1'b0;
        tag_q[e]    <= '0;
        last_q[e]   <= '0;
        stride_q[e] <= '0;
        cnt_q[e]    <= '0;
      end else if (sel) begin
        vld_q[e]    <= 1'b1;
        tag_q[e]    <= tag;
        last_q[e]   <= wr_last_i;
        stride_q[e] <= wr_stride_i;
        cnt_q[e]    <= wr_cnt_i;
      end
    end
  end

  assign hit_o    = vld_q[idx] && (tag_q[idx] == tag);
  assign last_o   = last_q[idx];
  assign stride_o = stride_q[idx];
  assign cnt_o    = cnt_q[idx];

endmodule

// File: rtl/stride_pf_train.sv
module stride_pf_train
  import stride_pf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  cfg_thresh_i,
  input  logic [CNT_W-1:0]  cfg_cnt_max_i,
  input  logic [ADDR_W-1:0] cfg_max_dist_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_last_o,
  output logic [ADDR_W-1:0] wr_stride_o,
  output logic [CNT_W-1:0]  wr_cnt_o,
  output logic              fire_o,
  output logic [ADDR_W-1:0] fire_addr_o
);

  train_act_e        act;
  logic [ADDR_W-1:0] diff;
  logic [ADDR_W-1:0] mag;
  logic [CNT_W-1:0]  cnt_sat;
  logic              in_reach;

  always_comb begin
    diff     = miss_addr_i - last_i;
    cnt_sat  = (cnt_i >= cfg_cnt_max_i) ? cfg_cnt_max_i : cnt_i + 1'b1;
    mag      = stride_i[ADDR_W-1] ? (~stride_i + 1'b1) : stride_i;
    in_reach = (mag <= cfg_max_dist_i);

    if (!hit_i)                act = ACT_ALLOC;
    else if (diff == stride_i) act = ACT_CONFIRM;
    else                       act = ACT_RETRAIN;

    wr_en_o     = miss_valid_i;
    wr_last_o   = miss_addr_i;
    wr_stride_o = '0;
    wr_cnt_o    = '0;
    fire_o      = 1'b0;

    unique case (act)
      ACT_ALLOC: begin
        wr_stride_o = '0;
        wr_cnt_o    = '0;
      end
      ACT_RETRAIN: begin
        wr_stride_o = diff;
        wr_cnt_o    = '0;
      end
      ACT_CONFIRM: begin
        wr_stride_o = stride_i;
        wr_cnt_o    = cnt_sat;
        fire_o      = miss_valid_i && (stride_i != '0) && in_reach &&
                      (cnt_sat > cfg_thresh_i);
      end
      default: ;
    endcase
  end

  assign fire_addr_o = miss_addr_i + stride_i;

endmodule

// File: rtl/stride_pf_req.sv
module stride_pf_req #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] fire_addr_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic stall;
  assign stall = valid_o && !ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else if (!stall) begin
      valid_o <= fire_i;
      if (fire_i) addr_o <= fire_addr_i;
    end
  end

endmodule

// File: rtl/stride_pf.sv
module stride_pf #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [PC_W-1:0]   miss_pc_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic [CNT_W-1:0]  cfg_thresh_i,
  input  logic [CNT_W-1:0]  cfg_cnt_max_i,
  input  logic [ADDR_W-1:0] cfg_max_dist_i,
  output logic              pf_valid_o,
  input  logic              pf_ready_i,
  output logic [ADDR_W-1:0] pf_addr_o
);

  logic              hit;
  logic [ADDR_W-1:0] last;
  logic [ADDR_W-1:0] stride;
  logic [CNT_W-1:0]  cnt;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_last;
  logic [ADDR_W-1:0] wr_stride;
  logic [CNT_W-1:0]  wr_cnt;
  logic              fire;
  logic [ADDR_W-1:0] fire_addr;

  stride_pf_table #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pc_i        (miss_pc_i),
    .hit_o       (hit),
    .last_o      (last),
    .stride_o    (stride),
    .cnt_o       (cnt),
    .wr_en_i     (wr_en),
    .wr_last_i   (wr_last),
    .wr_stride_i (wr_stride),
    .wr_cnt_i    (wr_cnt)
  );

  stride_pf_train #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_train (
    .miss_valid_i   (miss_valid_i),
    .miss_addr_i    (miss_addr_i),
    .hit_i          (hit),
    .last_i         (last),
    .stride_i       (stride),
    .cnt_i          (cnt),
    .cfg_thresh_i   (cfg_thresh_i),
    .cfg_cnt_max_i  (cfg_cnt_max_i),
    .cfg_max_dist_i (cfg_max_dist_i),
    .wr_en_o        (wr_en),
    .wr_last_o      (wr_last),
    .wr_stride_o    (wr_stride),
    .wr_cnt_o       (wr_cnt),
    .fire_o         (fire),
    .fire_addr_o    (fire_addr)
  );

  stride_pf_req #(
    .ADDR_W(ADDR_W)
  ) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .fire_addr_i (fire_addr),
    .valid_o     (pf_valid_o),
    .ready_i     (pf_ready_i),
    .addr_o      (pf_addr_o)
  );

endmodule

// File: rtl/stride_pf_chk.sv
module stride_pf_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              miss_valid_i,
  input logic [ADDR_W-1:0] miss_addr_i,
  input logic              pf_valid_o,
  input logic              pf_ready_i,
  input logic [ADDR_W-1:0] pf_addr_o
);

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o && !pf_ready_i |=> pf_valid_o && $stable(pf_addr_o));

  // R4
  rise_after_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pf_valid_o) |-> $past(miss_valid_i));

  // R6
  no_zero_stride_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pf_valid_o) |-> pf_addr_o != $past(miss_addr_i));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_valid_i && (!pf_valid_o || pf_ready_i) |=> !pf_valid_o);

endmodule

bind stride_pf stride_pf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .miss_valid_i (miss_valid_i),
  .miss_addr_i  (miss_addr_i),
  .pf_valid_o   (pf_valid_o),
  .pf_ready_i   (pf_ready_i),
  .pf_addr_o    (pf_addr_o)
);

// File: tb/stride_pf_bench.sv
module stride_pf_bench;

  localparam int unsigned PC_W   = 16;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned IDX_W  = 2;
  localparam int unsigned CNT_W  = 3;
  localparam int unsigned ENT    = 1 << IDX_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              miss_valid_i = 1'b0;
  logic [PC_W-1:0]   miss_pc_i = '0;
  logic [ADDR_W-1:0] miss_addr_i = '0;
  logic [CNT_W-1:0]  cfg_thresh_i = 3'd1;
  logic [CNT_W-1:0]  cfg_cnt_max_i = 3'd3;
  logic [ADDR_W-1:0] cfg_max_dist_i = 16'h0100;
  logic              pf_valid_o;
  logic              pf_ready_i = 1'b1;
  logic [ADDR_W-1:0] pf_addr_o;

  always #10 clk_i = ~clk_i;

  stride_pf #(.PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_stride_pf (
    .clk_i, .rst_ni, .miss_valid_i, .miss_pc_i, .miss_addr_i,
    .cfg_thresh_i, .cfg_cnt_max_i, .cfg_max_dist_i,
    .pf_valid_o, .pf_ready_i, .pf_addr_o
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int quiet_at = -1;
  string quiet_tag;
  bit running = 1'b0;

  logic [ADDR_W-1:0] exp_a[$];
  string             exp_t[$];

  // model state
  bit                mv [ENT];
  logic [PC_W-IDX_W-1:0] mt [ENT];
  logic [ADDR_W-1:0] ml [ENT];
  logic [ADDR_W-1:0] ms [ENT];
  logic [CNT_W-1:0]  mc [ENT];

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  task automatic miss(logic [PC_W-1:0] pc, logic [ADDR_W-1:0] addr, string tag);
    int i;
    logic [ADDR_W-1:0] d, mag;
    logic [CNT_W-1:0] nc;
    bit hit, fire, held;
    i = int'(pc[IDX_W-1:0]);
    hit = mv[i] && (mt[i] == pc[PC_W-1:IDX_W]);
    d = addr - ml[i];
    fire = 1'b0;
    if (!hit) begin
      mv[i] = 1'b1; mt[i] = pc[PC_W-1:IDX_W]; ml[i] = addr; ms[i] = '0; mc[i] = '0;
    end else if (d == ms[i]) begin
      nc = (mc[i] >= cfg_cnt_max_i) ? cfg_cnt_max_i : mc[i] + 1'b1;
      mc[i] = nc;
      mag = ms[i][ADDR_W-1] ? -ms[i] : ms[i];
      fire = (ms[i] != '0) && (mag <= cfg_max_dist_i) && (nc > cfg_thresh_i);
      ml[i] = addr;
    end else begin
      ms[i] = d; mc[i] = '0; ml[i] = addr;
    end
    held = !pf_ready_i && (exp_a.size() > 0);
    if (fire && !held) begin
      exp_a.push_back(addr + ms[i]);
      exp_t.push_back(tag);
    end else if (pf_ready_i || exp_a.size() == 0) begin
      quiet_at  = cyc + 1;
      quiet_tag = tag;
    end
    miss_valid_i = 1'b1;
    miss_pc_i    = pc;
    miss_addr_i  = addr;
    tick();
    miss_valid_i = 1'b0;
    tick();
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (running) begin
        if (pf_valid_o) begin
          if (exp_a.size() == 0) begin
            check(1'b0, "R4", "unexpected request", int'(pf_addr_o), 0);
          end else begin
            check(pf_addr_o == exp_a[0], exp_t[0], "prefetch address",
                  int'(pf_addr_o), int'(exp_a[0]));
            if (pf_ready_i) begin
              void'(exp_a.pop_front());
              void'(exp_t.pop_front());
            end
          end
        end
        if (cyc == quiet_at)
          check(!pf_valid_o, quiet_tag, "no request expected", int'(pf_valid_o), 0);
      end
    end
  end

  task automatic run_tests();
    for (int e = 0; e < int'(ENT); e++) mv[e] = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    @(negedge clk_i);
    check(!pf_valid_o, "R1", "valid after reset", int'(pf_valid_o), 0);
    running = 1'b1;
    tick();

    // R3 then R4: fresh stream, stride 16
    miss(16'h0040, 16'h1000, "R3");
    for (int k = 1; k < 6; k++) miss(16'h0040, 16'h1000 + 16'(16 * k), "R4");

    // R5: stride break, then retrain on stride 8
    miss(16'h0040, 16'h1100, "R5");
    for (int k = 1; k < 5; k++) miss(16'h0040, 16'h1100 + 16'(8 * k), "R5");

    // R11 and R10: interleaved positive and negative strides
    for (int k = 0; k < 6; k++) begin
      miss(16'h0041, 16'h2000 + 16'(8 * k), "R11");
      miss(16'h0042, 16'h0008 - 16'(4 * k), "R10");
    end

    // R6: repeated address
    for (int k = 0; k < 6; k++) miss(16'h0043, 16'h4000, "R6");

    // R2: alias at index 0 evicts pc 0x40
    miss(16'h0044, 16'h5000, "R2");
    miss(16'h0040, 16'h1128, "R2");
    for (int k = 1; k < 5; k++) miss(16'h0040, 16'h1128 + 16'(8 * k), "R2");

    // R8: stride 0x200 beyond bound, then bound raised
    for (int k = 0; k < 5; k++) miss(16'h0053, 16'h6000 + 16'(16'h200 * k), "R8");
    cfg_max_dist_i = 16'h0400;
    for (int k = 5; k < 7; k++) miss(16'h0053, 16'h6000 + 16'(16'h200 * k), "R8");
    cfg_max_dist_i = 16'h0100;

    // R7: ceiling equal to threshold, then raised
    cfg_cnt_max_i = 3'd1;
    for (int k = 0; k < 6; k++) miss(16'h0061, 16'h7000 + 16'(4 * k), "R7");
    cfg_cnt_max_i = 3'd3;
    for (int k = 6; k < 8; k++) miss(16'h0061, 16'h7000 + 16'(4 * k), "R7");

    // R9: hold under back-pressure
    for (int k = 0; k < 4; k++) begin
      miss(16'h0070, 16'h8000 + 16'(32 * k), "R9");
      miss(16'h0072, 16'h9000 + 16'(64 * k), "R9");
    end
    pf_ready_i = 1'b0;
    tick(); tick();
    miss(16'h0070, 16'h8080, "R9");
    miss(16'h0072, 16'h9100, "R9");
    tick(); tick(); tick();
    pf_ready_i = 1'b1;
    tick(); tick();
    miss(16'h0072, 16'h9140, "R9");

    tick(); tick(); tick(); tick();
    check(exp_a.size() == 0, "R4", "outstanding expected requests", exp_a.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk_i);
        check(1'b0, "R1", "watchdog expired", cyc, 0);
      end
    join_any
    running = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule